// File: doc/BRIEF.md
# Program ROM Bank Switcher

This block sits on the CPU side of a cartridge memory controller and turns every CPU access in the upper half of the address space into a physical program ROM address. The upper 32 KB is split into four 8 KB windows at 0x8000, 0xA000, 0xC000 and 0xE000. The window at 0xE000 always shows the last bank of the ROM. The window at 0xA000 shows a bank held in its own register. Two more registers feed the 0x8000 and 0xC000 windows: a programmable bank and an alternate bank that resets to the second-to-last bank. A swap flag sets which of those two windows each one drives.

The CPU loads these registers with writes decoded from address bits [15:12] and [3:0]. When the swap flag changes, the programmable and alternate registers trade contents in the same write. The banks visible in the windows therefore stay the same, and only the window reached by later programmable-bank writes moves. The block also holds a 2-bit nametable mirroring selection for the video side. The ROM size is the parameter `BANK_COUNT`, a power of two counting 8 KB banks. Bank numbers wrap modulo that count.

Top module: `prg_bank_switch`

## Requirements
- R1: After synchronous reset the windows selected by cpu_addr[14:13] = 0, 1, 2, 3 map to banks 0, 1, BANK_COUNT-2 and BANK_COUNT-1. mirror_sel is 0 and the swap flag is clear.
- R2: rom_addr is combinational and equals {bank of the window chosen by cpu_addr[14:13], cpu_addr[12:0]}. Window code 0 is 0x8000, 1 is 0xA000, 2 is 0xC000 and 3 is 0xE000.
- R3: The window with code 3 always maps to bank BANK_COUNT-1, whatever is written.
- R4: A write with cpu_addr[15:12] = 0x8 loads the programmable bank. It appears in window 0 when the swap flag is clear and in window 2 when it is set, from the clock edge that takes the write.
- R5: A write with cpu_addr[15:12] = 0xA loads the bank of window 1.
- R6: A write with cpu_addr[15:12] = 0x9 and cpu_addr[3:0] = 1 or 4 sets the swap flag from cpu_wdata[1]. No window changes the bank it shows because of such a write.
- R7: A write with cpu_addr[15:12] = 0x9 and cpu_addr[3:0] = 0 sets mirror_sel to cpu_wdata[1:0]. The codes are 0 vertical, 1 horizontal, 2 single-screen lower and 3 single-screen upper.
- R8: cpu_addr[11:4] plays no part in register selection. A write at 0x9 with any other low nibble changes neither mirror_sel nor the swap flag.
- R9: Bank numbers are taken modulo BANK_COUNT. For example, 0x13 with BANK_COUNT = 16 gives bank 3.
- R10: While cpu_wr is low no register changes, whatever cpu_addr and cpu_wdata hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Write strobe for cpu_addr/cpu_wdata |
| cpu_addr | input | 16 | CPU address, used for both register decode and translation |
| cpu_wdata | input | 8 | CPU write data |
| rom_addr | output | log2(BANK_COUNT)+13 | Physical program ROM address |
| mirror_sel | output | 2 | Nametable mirroring code |

## Verification
The bench toggles the swap flag both ways and then checks that no window changed. A design that moved the windows without exchanging the register contents would show a different bank at 0x8000 or 0xC000 there. Later programmable-bank writes must then land in the other window, which catches a design that ignores the flag. Mode writes at the non-decoding low nibbles and writes with scattered middle address bits check that decoding looks only at bits [15:12] and [3:0]. An oversized bank number checks the modulo wrap, and held data with the strobe low checks that nothing is loaded without it. Random writes across all upper nibbles, tracked against a bench model, catch stray loads from the unused nibbles and any write to the fixed top window.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;
  localparam int ADDR_W    = 16;
  localparam int OFS_W     = 13;
  localparam int WIN_COUNT = 4;

  localparam logic [3:0] NIB_PROG = 4'h8;
  localparam logic [3:0] NIB_CTRL = 4'h9;
  localparam logic [3:0] NIB_MID  = 4'hA;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORIZ  = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  typedef struct packed {
    logic ld_prog;
    logic ld_mid;
    logic ld_mirror;
    logic ld_mode;
  } wr_strobe_t;
endpackage

// File: rtl/prg_bank_decode.sv
module prg_bank_decode
  import prg_bank_pkg::*;
(
  input  logic       wr_en,
  input  logic [3:0] hi_nib,
  input  logic [3:0] lo_nib,
  output wr_strobe_t stb
);
  logic mode_slot;

  always_comb begin
    mode_slot     = (lo_nib == 4'h1) || (lo_nib == 4'h4);
    stb.ld_prog   = wr_en && (hi_nib == NIB_PROG);
    stb.ld_mid    = wr_en && (hi_nib == NIB_MID);
    stb.ld_mirror = wr_en && (hi_nib == NIB_CTRL) && (lo_nib == 4'h0);
    stb.ld_mode   = wr_en && (hi_nib == NIB_CTRL) && mode_slot;
  end
endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_bank_pkg::*;
#(
  parameter int BANK_COUNT = 16,
  parameter int DATA_W     = 8,
  localparam int BANK_W    = $clog2(BANK_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_strobe_t        stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic [BANK_W-1:0] prog_q,
  output logic [BANK_W-1:0] alt_q,
  output logic [BANK_W-1:0] mid_q,
  output logic              swap_q,
  output mirror_e           mirror_q
);
  logic [BANK_W-1:0] wr_bank;

  // Masking to BANK_W bits gives the modulo-BANK_COUNT wrap (R9).
  assign wr_bank = wr_data[BANK_W-1:0];

  generate
    if (BANK_W < DATA_W) begin : g_drop_hi
      logic unused_hi;
      assign unused_hi = ^wr_data[DATA_W-1:BANK_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q   <= '0;
      alt_q    <= BANK_W'(BANK_COUNT - 2);
      mid_q    <= BANK_W'(1);
      swap_q   <= 1'b0;
      mirror_q <= MIR_VERT;
    end else begin
      if (stb.ld_prog)   prog_q   <= wr_bank;
      if (stb.ld_mid)    mid_q    <= wr_bank;
      if (stb.ld_mirror) mirror_q <= mirror_e'(wr_data[1:0]);
      if (stb.ld_mode && (wr_data[1] != swap_q)) begin
        prog_q <= alt_q;
        alt_q  <= prog_q;
        swap_q <= wr_data[1];
      end
    end
  end
endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
  import prg_bank_pkg::*;
#(
  parameter int BANK_COUNT = 16,
  localparam int BANK_W    = $clog2(BANK_COUNT),
  localparam int ROM_AW    = BANK_W + OFS_W
) (
  input  logic [BANK_W-1:0]                prog_q,
  input  logic [BANK_W-1:0]                alt_q,
  input  logic [BANK_W-1:0]                mid_q,
  input  logic                             swap_q,
  input  logic [1:0]                       win_sel,
  input  logic [OFS_W-1:0]                 offset,
  output logic [WIN_COUNT-1:0][BANK_W-1:0] win_bank,
  output logic [ROM_AW-1:0]                rom_addr
);
  generate
    for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win
      if (w == 0) begin : g_low
        assign win_bank[w] = swap_q ? alt_q : prog_q;
      end else if (w == 1) begin : g_mid
        assign win_bank[w] = mid_q;
      end else if (w == 2) begin : g_high
        assign win_bank[w] = swap_q ? prog_q : alt_q;
      end else begin : g_top
        assign win_bank[w] = BANK_W'(BANK_COUNT - 1);
      end
    end
  endgenerate

  assign rom_addr = {win_bank[win_sel], offset};
endmodule

// File: rtl/prg_bank_switch.sv
module prg_bank_switch
  import prg_bank_pkg::*;
#(
  parameter int BANK_COUNT = 16,
  parameter int DATA_W     = 8,
  localparam int BANK_W    = $clog2(BANK_COUNT),
  localparam int ROM_AW    = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [1:0]        mirror_sel
);
  wr_strobe_t                     stb;
  logic [BANK_W-1:0]              prog_q;
  logic [BANK_W-1:0]              alt_q;
  logic [BANK_W-1:0]              mid_q;
  logic                           swap_q;
  mirror_e                        mirror_q;
  logic [WIN_COUNT-1:0][BANK_W-1:0] win_bank;

  prg_bank_decode u_decode (
    .wr_en  (cpu_wr),
    .hi_nib (cpu_addr[15:12]),
    .lo_nib (cpu_addr[3:0]),
    .stb    (stb)
  );

  prg_bank_regs #(.BANK_COUNT(BANK_COUNT), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .wr_data  (cpu_wdata),
    .prog_q   (prog_q),
    .alt_q    (alt_q),
    .mid_q    (mid_q),
    .swap_q   (swap_q),
    .mirror_q (mirror_q)
  );

  prg_window_map #(.BANK_COUNT(BANK_COUNT)) u_map (
    .prog_q   (prog_q),
    .alt_q    (alt_q),
    .mid_q    (mid_q),
    .swap_q   (swap_q),
    .win_sel  (cpu_addr[14:13]),
    .offset   (cpu_addr[OFS_W-1:0]),
    .win_bank (win_bank),
    .rom_addr (rom_addr)
  );

  assign mirror_sel = mirror_q;
endmodule

// File: rtl/prg_bank_switch_chk.sv
module prg_bank_switch_chk #(
  parameter int BANK_COUNT = 16,
  parameter int BANK_W     = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      cpu_wr,
  input logic [15:0]               cpu_addr,
  input logic [BANK_W-1:0]         wr_bank,
  input logic [1:0]                wr_mir,
  input logic [BANK_W+12:0]        rom_addr,
  input logic [1:0]                mirror_sel,
  input logic [3:0][BANK_W-1:0]    win_bank,
  input logic                      swap
);
  logic is_mode;
  assign is_mode = (cpu_addr[15:12] == 4'h9) &&
                   ((cpu_addr[3:0] == 4'h1) || (cpu_addr[3:0] == 4'h4));

  // R2: low offset passes straight through
  a_r2_offset: assert property (@(posedge clk) disable iff (rst)
    rom_addr[12:0] == cpu_addr[12:0]);

  // R3: top window seen at the ROM address is always the last bank
  a_r3_top_fixed: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[14:13] == 2'b11) |-> (rom_addr[BANK_W+12:13] == BANK_W'(BANK_COUNT - 1)));

  // R4: programmable bank lands in the window picked by the swap flag
  a_r4_prog_target: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[15:12] == 4'h8) |=>
      ($past(swap) ? (win_bank[2] == $past(wr_bank)) : (win_bank[0] == $past(wr_bank))));

  // R5: middle window load
  a_r5_mid_load: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[15:12] == 4'hA) |=> (win_bank[1] == $past(wr_bank)));

  // R6: a mode write never changes what the windows show
  a_r6_mode_keeps_banks: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && is_mode) |=> $stable(win_bank));

  // R7: mirroring load
  a_r7_mirror_load: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[15:12] == 4'h9 && cpu_addr[3:0] == 4'h0) |=>
      (mirror_sel == $past(wr_mir)));

  // R10: no strobe, no change
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !cpu_wr |=> ($stable(win_bank) && $stable(mirror_sel) && $stable(swap)));
endmodule

bind prg_bank_switch prg_bank_switch_chk #(.BANK_COUNT(BANK_COUNT), .BANK_W(BANK_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_wr     (cpu_wr),
  .cpu_addr   (cpu_addr),
  .wr_bank    (cpu_wdata[BANK_W-1:0]),
  .wr_mir     (cpu_wdata[1:0]),
  .rom_addr   (rom_addr),
  .mirror_sel (mirror_sel),
  .win_bank   (win_bank),
  .swap       (swap_q)
);

// File: tb/prg_bank_switch_test.sv
module prg_bank_switch_test;
  localparam int CLK_PERIOD = 10;
  localparam int BANK_COUNT = 16;
  localparam int BANK_W     = 4;
  localparam int ROM_AW     = BANK_W + 13;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpu_wr = 1'b0;
  logic [15:0]       cpu_addr = 16'h8000;
  logic [7:0]        cpu_wdata = 8'h00;
  logic [ROM_AW-1:0] rom_addr;
  logic [1:0]        mirror_sel;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model
  int m_prog, m_alt, m_mid, m_mir;
  bit m_swap;

  always #(CLK_PERIOD/2) clk = ~clk;

  prg_bank_switch #(.BANK_COUNT(BANK_COUNT)) uut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .rom_addr(rom_addr), .mirror_sel(mirror_sel)
  );

  function automatic int exp_bank(int w);
    int b;
    case (w)
      0:       b = m_swap ? m_alt : m_prog;
      1:       b = m_mid;
      2:       b = m_swap ? m_prog : m_alt;
      default: b = BANK_COUNT - 1;
    endcase
    return b % BANK_COUNT;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic check_win(input int w, input string tag);
    logic [15:0] a;
    int exp;
    a = {1'b1, 2'(w), 13'($urandom)};
    cpu_addr = a;
    #1;
    exp = exp_bank(w) * 8192 + int'(a[12:0]);
    check(tag, int'(rom_addr), exp);
  endtask

  task automatic check_mirror(input string tag);
    check(tag, int'(mirror_sel), m_mir);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    logic [3:0] hi, lo;
    int t;
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
    hi = a[15:12]; lo = a[3:0];
    if (hi == 4'h8) m_prog = d % BANK_COUNT;
    if (hi == 4'hA) m_mid = d % BANK_COUNT;
    if (hi == 4'h9 && lo == 4'h0) m_mir = int'(d[1:0]);
    if (hi == 4'h9 && (lo == 4'h1 || lo == 4'h4) && (d[1] != m_swap)) begin
      t = m_prog; m_prog = m_alt; m_alt = t; m_swap = d[1];
    end
  endtask

  task automatic check_all(input string tag);
    for (int w = 0; w < 4; w++) check_win(w, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    logic [3:0] lo_pick [8];
    void'($urandom(32'd2024));
    lo_pick = '{4'h0, 4'h1, 4'h4, 4'h2, 4'h3, 4'h8, 4'hC, 4'hF};
    m_prog = 0; m_alt = BANK_COUNT - 2; m_mid = 1; m_mir = 0; m_swap = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset banks 0,1,14,15 and mirror 0
    check_win(0, "R1 window0"); check_win(1, "R1 window1");
    check_win(2, "R1 window2"); check_win(3, "R1 window3");
    check_mirror("R1 mirror");

    // R5: middle window load
    do_write(16'hA000, 8'h05);
    check_win(1, "R5 mid bank");
    // R4: programmable bank with swap clear goes to window 0
    do_write(16'h8123, 8'h07);
    check_win(0, "R4 swap clear window0");
    check_win(2, "R4 swap clear window2");
    // R6: set swap, windows unchanged
    do_write(16'h9001, 8'h02);
    check_all("R6 toggle on keeps banks");
    // R4: with swap set the load reaches window 2
    do_write(16'h8000, 8'h09);
    check_win(2, "R4 swap set window2");
    check_win(0, "R4 swap set window0");
    // R6: clear swap through the other mode slot
    do_write(16'h9004, 8'h00);
    check_all("R6 toggle off keeps banks");
    // R7: mirroring codes
    do_write(16'h9000, 8'hFE);
    check_mirror("R7 mirror single lower");
    // R8: middle address bits ignored
    do_write(16'h9FF0, 8'h01);
    check_mirror("R8 mirror via 0x9FF0");
    // R8: other low nibbles at 0x9 change nothing
    do_write(16'h9002, 8'h03);
    check_mirror("R8 mirror after 0x9002");
    do_write(16'h9003, 8'h02);
    do_write(16'h8000, 8'h0B);
    check_win(0, "R8 swap unchanged after 0x9003");
    // R9: modulo wrap
    do_write(16'h8000, 8'h13);
    check_win(0, "R9 bank wrap");
    // R10: strobe low
    @(negedge clk);
    cpu_addr = 16'hA000; cpu_wdata = 8'h0C;
    @(negedge clk);
    @(negedge clk);
    check_win(1, "R10 no load without strobe");
    // R3: writes in the top region leave the top window fixed
    do_write(16'hE000, 8'h00);
    do_write(16'hF001, 8'h02);
    check_win(3, "R3 top window fixed");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      int w;
      a = {4'(8 + ($urandom % 8)), 8'($urandom), lo_pick[$urandom % 8]};
      do_write(a, 8'($urandom));
      w = $urandom % 4;
      check_win(w, (w == 3) ? "R3 random top" : "R2 random window");
      check_mirror("R7 random mirror");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule